// File: doc/BRIEF.md
# Four-Deep Return-Address Stack

This block holds the return addresses of microprogram subroutine calls. Each entry is a 12-bit address. A push strobe stores the word on the write-data input, which is normally the incremented microprogram counter. A pop strobe discards the newest entry. The top output always shows the word at the current read position, so the sequencer can select it as the next address in the same cycle that it issues a return.

Two small pointers track the slots. The write pointer names the slot that the next push fills. The read pointer names the slot shown on the top output. A one-hot decoder turns the chosen write slot into a per-word write enable, and a multiplexer indexed by the read pointer drives the top output. An occupancy counter produces the full and empty flags. The counter also defines what happens when a push arrives at a full stack or a pop arrives at an empty one. A synchronous clear returns both pointers and the counter to zero. The asynchronous reset also zeroes the stored words.

Top module: `ret_addr_stack`

## Requirements
- R1: After `rst_n` is released, `empty_o` is 1, `full_o` is 0 and `top_o` is 0.
- R2: A push without a pop, with `clr_i` low, stores `wdata_i`. From the next cycle, `top_o` equals that word and `empty_o` is 0.
- R3: A pop without a push, on a non-empty stack, removes the newest entry. From the next cycle, `top_o` shows the entry pushed before it. Entries come back in last-in, first-out order.
- R4: `full_o` is 1 exactly when the stack holds 4 entries, and `empty_o` is 1 exactly when it holds none.
- R5: A push while full replaces the oldest entry. `full_o` stays 1, and the next four pops return the four newest words, newest first.
- R6: A pop while empty changes no state. `empty_o` stays 1, `full_o` stays 0, and a later push and pop behave as they would on a freshly cleared stack.
- R7: A push and a pop in the same cycle on a non-empty stack replace the top word in place. The entry count is unchanged, and the entry below it is still returned by the following pop.
- R8: A push and a pop in the same cycle on an empty stack act as a plain push.
- R9: `clr_i` has priority over push and pop. The cycle after it, `empty_o` is 1 and `full_o` is 0, and no word is written.
- R10: With push, pop and clear all low, the top word and both flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; zeroes pointers, count and words |
| clr_i | input | 1 | Synchronous clear of pointers and count |
| push_i | input | 1 | Store `wdata_i` as the new top entry |
| pop_i | input | 1 | Discard the top entry |
| wdata_i | input | 12 | Address to store on a push |
| top_o | output | 12 | Word at the current read position |
| full_o | output | 1 | Stack holds 4 entries |
| empty_o | output | 1 | Stack holds no entries |

## Verification
Every result is due one clock edge after its stimulus. The pointers, the count and the storage words are all registered, and the top output and both flags are decoded from those registers with no further register in the path. The bench applies each strobe for exactly one cycle, starting at a falling edge. It reads the outputs at the next falling edge, which is half a period after the edge that updates them, and only then drives the next stimulus. Sequences such as overflow, underflow and in-place replacement are checked at every step rather than only at the end, so that an effect arriving a cycle late or early shows up as a mismatch.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_PUSH    = 2'd1,
        OP_POP     = 2'd2,
        OP_REPLACE = 2'd3
    } stack_op_e;

    // Resolve the strobes into one operation; empty turns pop into idle
    // and push+pop into a plain push.
    function automatic stack_op_e classify(input logic push, input logic pop,
                                           input logic is_empty);
        if (push && pop && !is_empty) return OP_REPLACE;
        if (push)                     return OP_PUSH;
        if (pop && !is_empty)         return OP_POP;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t state_d, state_q;
    stack_op_e  op;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_TOP) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_TOP : p - 1'b1;
    endfunction

    assign empty_o  = (state_q.cnt == '0);
    assign full_o   = (state_q.cnt == CNT_MAX);
    assign rd_ptr_o = state_q.rd;
    assign op       = classify(push_i, pop_i, empty_o);

    always_comb begin
        state_d  = state_q;
        wr_en_o  = 1'b0;
        wr_idx_o = state_q.wr;
        if (clr_i) begin
            state_d = '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    wr_en_o     = 1'b1;
                    wr_idx_o    = state_q.wr;
                    state_d.rd  = state_q.wr;
                    state_d.wr  = ptr_inc(state_q.wr);
                    if (state_q.cnt != CNT_MAX)
                        state_d.cnt = state_q.cnt + 1'b1;
                end
                OP_REPLACE: begin
                    wr_en_o  = 1'b1;
                    wr_idx_o = state_q.rd;
                end
                OP_POP: begin
                    state_d.wr  = ptr_dec(state_q.wr);
                    state_d.rd  = ptr_dec(state_q.rd);
                    state_d.cnt = state_q.cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R9: clear empties the stack on the next cycle
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (empty_o && !full_o));

    // R6: popping an empty stack leaves it empty
    a_r6_pop_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i && !clr_i) |=> empty_o);

    // R5: a push into a full stack keeps it full
    a_r5_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !clr_i) |=> full_o);

    // R10: idle cycles move no pointer
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i && !clr_i) |=> ($stable(state_q.rd) && $stable(state_q.wr)));

    // R3: with entries present the read slot sits just behind the write slot
    a_r3_ptr_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_o |-> (ptr_inc(state_q.rd) == state_q.wr));

    // R4: the two flags never coincide
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

endmodule

// File: rtl/rs_wr_decode.sv
module rs_wr_decode #(
    parameter int DEPTH = 4,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             en_i,
    input  logic [PTR_W-1:0] idx_i,
    output logic [DEPTH-1:0] onehot_o
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign onehot_o[i] = en_i && (idx_i == PTR_W'(i));
    end

endmodule

// File: rtl/rs_word_array.sv
module rs_word_array #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 4,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] we_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] word_d [DEPTH];
    logic [WIDTH-1:0] word_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            word_d[i] = we_i[i] ? wdata_i : word_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) word_q[i] <= word_d[i];
        end
    end

    assign rdata_o = word_q[rd_ptr_i];

    // R2: at most one slot is written per cycle
    a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_i));

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] top_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_ptr;
    logic [DEPTH-1:0] slot_we;

    rs_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_ptr_o (rd_ptr),
        .full_o   (full_o),
        .empty_o  (empty_o)
    );

    rs_wr_decode #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_dec (
        .en_i     (wr_en),
        .idx_i    (wr_idx),
        .onehot_o (slot_we)
    );

    rs_word_array #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (slot_we),
        .wdata_i  (wdata_i),
        .rd_ptr_i (rd_ptr),
        .rdata_o  (top_o)
    );

    // R2: a lone push shows its word on top next cycle
    a_r2_push_to_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !clr_i) |=> (top_o == $past(wdata_i)) && !empty_o);

    // R7: push with pop on a non-empty stack rewrites the top word
    a_r7_replace_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !clr_i && !empty_o) |=> (top_o == $past(wdata_i)));

    // R10: the top word holds while no strobe is active
    a_r10_top_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i && !clr_i) |=> $stable(top_o));

endmodule

// File: tb/ret_addr_stack_test.sv
module ret_addr_stack_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [11:0] wdata_i = '0;
    logic [11:0] top_o;
    logic        full_o;
    logic        empty_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    ret_addr_stack uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .push_i(push_i),
        .pop_i(pop_i), .wdata_i(wdata_i), .top_o(top_o),
        .full_o(full_o), .empty_o(empty_o)
    );

    task automatic check(input string req, input string what,
                         input logic [11:0] got, input logic [11:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic flags(input string req, input logic e, input logic f);
        check(req, "empty", {11'd0, empty_o}, {11'd0, e});
        check(req, "full",  {11'd0, full_o},  {11'd0, f});
    endtask

    // One cycle of stimulus, applied at a falling edge and released at the next.
    task automatic step(input logic p, input logic q, input logic c,
                        input logic [11:0] d);
        push_i = p; pop_i = q; clr_i = c; wdata_i = d;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; clr_i = 1'b0; wdata_i = '0;
    endtask

    task automatic do_push(input logic [11:0] d); step(1'b1, 1'b0, 1'b0, d); endtask
    task automatic do_pop();                      step(1'b0, 1'b1, 1'b0, '0); endtask
    task automatic do_clear();                    step(1'b0, 1'b0, 1'b1, '0); endtask

    task automatic t_reset();
        flags("R1", 1'b1, 1'b0);
        check("R1", "top after reset", top_o, 12'h000);
    endtask

    task automatic t_lifo();
        do_clear();
        do_push(12'h111); check("R2", "top", top_o, 12'h111); flags("R2", 1'b0, 1'b0);
        do_push(12'h222); check("R2", "top", top_o, 12'h222);
        do_push(12'h333); check("R2", "top", top_o, 12'h333);
        do_pop();  check("R3", "top", top_o, 12'h222);
        do_pop();  check("R3", "top", top_o, 12'h111); flags("R3", 1'b0, 1'b0);
        do_pop();  flags("R3", 1'b1, 1'b0);
    endtask

    task automatic t_fill_overflow();
        do_clear();
        do_push(12'hA01); do_push(12'hA02); do_push(12'hA03);
        flags("R4", 1'b0, 1'b0);
        do_push(12'hA04); flags("R4", 1'b0, 1'b1);
        check("R4", "top when full", top_o, 12'hA04);
        do_push(12'hA05); flags("R5", 1'b0, 1'b1);
        check("R5", "top after overflow", top_o, 12'hA05);
        do_pop(); check("R5", "pop1", top_o, 12'hA04); flags("R5", 1'b0, 1'b0);
        do_pop(); check("R5", "pop2", top_o, 12'hA03);
        do_pop(); check("R5", "pop3", top_o, 12'hA02);
        do_pop(); flags("R5", 1'b1, 1'b0);
    endtask

    task automatic t_underflow();
        do_clear();
        do_push(12'h0AA);
        do_pop();  flags("R6", 1'b1, 1'b0);
        do_pop();  flags("R6", 1'b1, 1'b0);
        do_pop();  flags("R6", 1'b1, 1'b0);
        do_push(12'h0BB); check("R6", "top", top_o, 12'h0BB); flags("R6", 1'b0, 1'b0);
        do_push(12'h0CC);
        do_pop();  check("R6", "top", top_o, 12'h0BB);
        do_pop();  flags("R6", 1'b1, 1'b0);
    endtask

    task automatic t_replace();
        do_clear();
        do_push(12'h100); do_push(12'h200);
        step(1'b1, 1'b1, 1'b0, 12'h2FF);
        check("R7", "replaced top", top_o, 12'h2FF); flags("R7", 1'b0, 1'b0);
        do_pop(); check("R7", "below top", top_o, 12'h100);
        do_pop(); flags("R7", 1'b1, 1'b0);
        do_push(12'h301); do_push(12'h302); do_push(12'h303); do_push(12'h304);
        step(1'b1, 1'b1, 1'b0, 12'h3FF);
        flags("R7", 1'b0, 1'b1); check("R7", "replace when full", top_o, 12'h3FF);
        do_pop(); check("R7", "below after full replace", top_o, 12'h303);
    endtask

    task automatic t_replace_empty();
        do_clear();
        step(1'b1, 1'b1, 1'b0, 12'h0DD);
        check("R8", "top", top_o, 12'h0DD); flags("R8", 1'b0, 1'b0);
        do_pop(); flags("R8", 1'b1, 1'b0);
    endtask

    task automatic t_clear_priority();
        do_clear();
        do_push(12'h501); do_push(12'h502); do_push(12'h503); do_push(12'h504);
        step(1'b1, 1'b0, 1'b1, 12'h555);
        flags("R9", 1'b1, 1'b0);
        do_push(12'h666); check("R9", "push after clear", top_o, 12'h666);
        do_pop(); flags("R9", 1'b1, 1'b0);
    endtask

    task automatic t_idle();
        do_clear();
        do_push(12'h777);
        step(1'b0, 1'b0, 1'b0, 12'hFFF);
        step(1'b0, 1'b0, 1'b0, 12'h123);
        step(1'b0, 1'b0, 1'b0, 12'h000);
        check("R10", "top held", top_o, 12'h777); flags("R10", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lifo();
        t_fill_overflow();
        t_underflow();
        t_replace();
        t_replace_empty();
        t_clear_priority();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule